// File: doc/BRIEF.md
# PCI Configuration Register File

This block holds the 256-byte configuration space of a PCI function as 64 registers of 32 bits each. Every register carries its own writable-bit mask. A host write changes only the bits that the mask opens, so identity fields, the header type and hard-wired encodings keep their values however they are written. Elaboration parameters supply the identity fields, the header flavour (endpoint or bridge), the interrupt routing and the setup of up to six base address registers. Reset loads all of these.

The host reads one full register at a time through a registered read port that names a register index. It writes through a port that takes a byte address, a data value and an access size of 1, 2 or 4 bytes. For byte and word accesses the value sits in the low bits of the write data and is moved to the addressed lanes. The writable mask of a base address register is the inverse of its region size minus one. Enumeration software therefore writes all ones and reads the register back to learn the size.

A 64-bit memory region takes two neighbouring slots, and the upper slot holds address bits 63:32. Reset also turns on memory or I/O decode in the command register, depending on which kinds of region are configured.

Top module: `pcfg_regfile`

## Requirements
- R1: After reset, register 0 reads {device ID, vendor ID}, register 2 reads {class, subclass, programming interface, revision} from bit 31 down, and register 11 reads {subsystem ID, subsystem vendor ID}. All three ignore every write.
- R2: A read request is answered on rd_data one clock later. An index of 64 or above returns 0xFFFFFFFF. rd_data holds its value while no read is requested.
- R3: A write sets register = (old & ~(mask & lanes)) | (data & mask & lanes). A write aimed only at read-only bits leaves the register unchanged.
- R4: Register 1 is writable in bits 15:0 (command) and always reads 0 in bits 31:16.
- R5: A 4-byte write needs byte address bits 1:0 = 0, a 2-byte write needs bit 0 = 0, and a 1-byte write is accepted at any offset. Sizes other than 1, 2 and 4 are ignored, and so are byte addresses of 256 or above.
- R6: For header type 0, register 3 resets to 0x00000000, register 9 is read-only and register 15 has mask 0x000000FF. For header type 1, register 3 resets to 0x00010000, register 9 has mask 0xFFF0FFF0 and register 15 has mask 0xFFFF00FF. In both, register 3 is writable in bits 7:0.
- R7: BAR n sits at register 4+n, and its mask is ~(size-1). A memory BAR keeps bit 3 = prefetchable and bits 2:1 = 2'b10 for a 64-bit region or 2'b00 for a 32-bit region. An I/O BAR keeps bit 0 = 1. An unused slot reads 0 and ignores writes.
- R8: A 64-bit BAR at slot n makes slot n+1 hold address bits 63:32, with mask ~((size-1) >> 32).
- R9: Reset sets command bit 1 when any memory BAR is configured and command bit 0 when any I/O BAR is configured.
- R10: Register 15 bits 15:8 read the interrupt pin, counted from 1 (pin A = 1), and cannot be written. Bits 7:0 hold the writable interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads parameter values |
| rd_en | input | 1 | Read request |
| rd_idx | input | RD_IDX_W | Register index to read |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Write request |
| wr_addr | input | RD_IDX_W+2 | Byte address of the write |
| wr_size | input | 3 | Access size in bytes (1, 2 or 4) |
| wr_data | input | 32 | Write value, right-aligned for byte and word writes |

## Verification
Sizing a BAR is the hardest case to reach. Reset must first place an aligned address and a size-derived mask in the slot. An all-ones write must then keep the type bits and clear exactly the low size bits. For a 64-bit region the upper slot must clear a single bit. The bench sets up a 4 KiB memory region, a 32-byte I/O region and an 8 GiB prefetchable 64-bit region through parameters, then writes all ones to each slot and reads it back. A second instance built as a bridge has its own masks for registers 9 and 15 probed the same way. Byte-address aliasing is probed by writing beyond the space to an address whose low index bits hit a writable register.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  // Base address register kinds, two bits per slot in the BAR_KIND parameter
  typedef enum logic [1:0] {
    BAR_NONE  = 2'd0,
    BAR_MEM32 = 2'd1,
    BAR_MEM64 = 2'd2,
    BAR_IO    = 2'd3
  } bar_kind_e;

  localparam int REG_ID      = 0;
  localparam int REG_CMD     = 1;
  localparam int REG_CLASS   = 2;
  localparam int REG_HDR     = 3;
  localparam int REG_BAR0    = 4;
  localparam int REG_BRWIN   = 9;
  localparam int REG_SUBSYS  = 11;
  localparam int REG_IRQ     = 15;

  localparam logic [31:0] MEM_ADDR_MASK = 32'hFFFF_FFF0;
  localparam logic [31:0] IO_ADDR_MASK  = 32'hFFFF_FFFC;
endpackage

// File: rtl/pcfg_init.sv
module pcfg_init
  import pcfg_pkg::*;
#(
  parameter int          NREG       = 64,
  parameter int          NBAR       = 6,
  parameter logic [15:0] VENDOR_ID  = 16'h0000,
  parameter logic [15:0] DEVICE_ID  = 16'h0000,
  parameter logic [7:0]  CLASS_CODE = 8'h00,
  parameter logic [7:0]  SUBCLASS   = 8'h00,
  parameter logic [7:0]  PROG_IF    = 8'h00,
  parameter logic [7:0]  REVISION   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h0000,
  parameter logic [15:0] SUBSYS_ID  = 16'h0000,
  parameter bit          HDR_BRIDGE = 1'b0,
  parameter logic [1:0]  IRQ_PIN_SEL = 2'd0,
  parameter logic [7:0]  IRQ_LINE   = 8'h00,
  parameter logic [2*NBAR-1:0]  BAR_KIND = '0,
  parameter logic [6*NBAR-1:0]  BAR_LOG2 = '0,
  parameter logic [NBAR-1:0]    BAR_PREF = '0,
  parameter logic [64*NBAR-1:0] BAR_ADDR = '0
) (
  output logic [NREG-1:0][31:0] init_val,
  output logic [NREG-1:0][31:0] init_mask
);

  function automatic logic [63:0] size_m1(int n);
    return (64'd1 << BAR_LOG2[6*n +: 6]) - 64'd1;
  endfunction

  function automatic logic [1:0] kind_of(int n);
    return BAR_KIND[2*n +: 2];
  endfunction

  function automatic logic [1:0] decode_enables();
    logic [1:0] en;
    en = 2'b00;
    for (int n = 0; n < NBAR; n++) begin
      if (kind_of(n) == BAR_MEM32 || kind_of(n) == BAR_MEM64) en[1] = 1'b1;
      if (kind_of(n) == BAR_IO) en[0] = 1'b1;
    end
    return en;
  endfunction

  // Reset value and writable mask of one register, packed as {value, mask}
  function automatic logic [63:0] reg_setup(int r);
    logic [31:0] v, m, lo_m;
    logic [63:0] a, sm;
    int n;
    v = '0;
    m = '0;
    case (r)
      REG_ID:     v = {DEVICE_ID, VENDOR_ID};
      REG_CMD:    begin v = {30'd0, decode_enables()}; m = 32'h0000_FFFF; end
      REG_CLASS:  v = {CLASS_CODE, SUBCLASS, PROG_IF, REVISION};
      REG_HDR:    begin v = HDR_BRIDGE ? 32'h0001_0000 : 32'h0; m = 32'h0000_00FF; end
      REG_SUBSYS: v = {SUBSYS_ID, SUBSYS_VID};
      REG_IRQ: begin
        v = {16'h0, 8'(IRQ_PIN_SEL) + 8'd1, IRQ_LINE};
        m = HDR_BRIDGE ? 32'hFFFF_00FF : 32'h0000_00FF;
      end
      default: ;
    endcase
    if (r == REG_BRWIN && HDR_BRIDGE) m = 32'hFFF0_FFF0;
    if (r >= REG_BAR0 && r < REG_BAR0 + NBAR) begin
      n    = r - REG_BAR0;
      sm   = size_m1(n);
      a    = BAR_ADDR[64*n +: 64];
      lo_m = ~sm[31:0];
      case (kind_of(n))
        BAR_MEM32, BAR_MEM64: begin
          v = (a[31:0] & lo_m & MEM_ADDR_MASK) |
              {28'd0, BAR_PREF[n], kind_of(n) == BAR_MEM64, 2'b00};
          m = lo_m & MEM_ADDR_MASK;
        end
        BAR_IO: begin
          v = (a[31:0] & lo_m & IO_ADDR_MASK) | 32'd1;
          m = lo_m & IO_ADDR_MASK;
        end
        default: ;
      endcase
      if (n > 0 && kind_of(n) == BAR_NONE && kind_of(n-1) == BAR_MEM64) begin
        sm = size_m1(n-1);
        a  = BAR_ADDR[64*(n-1) +: 64];
        v  = a[63:32];
        m  = ~sm[63:32];
      end
    end
    return {v, m};
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [63:0] setup;
    assign setup        = reg_setup(r);
    assign init_val[r]  = setup[63:32];
    assign init_mask[r] = setup[31:0];
  end

endmodule

// File: rtl/pcfg_wr_lane.sv
module pcfg_wr_lane #(
  parameter int NREG  = 64,
  parameter int AW    = 10,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [2:0]       wr_size,
  input  logic [31:0]      wr_data,
  output logic             wr_go,
  output logic [IDX_W-1:0] wr_idx,
  output logic [31:0]      lane_mask,
  output logic [31:0]      lane_data
);
  logic [1:0] off;
  logic       legal;
  logic       in_range;
  logic [4:0] shamt;

  assign off      = wr_addr[1:0];
  assign shamt    = {off, 3'b000};
  assign in_range = wr_addr[AW-1:2] < (AW-2)'(NREG);
  assign wr_idx   = wr_addr[IDX_W+1:2];

  always_comb begin
    legal     = 1'b0;
    lane_mask = '0;
    case (wr_size)
      3'd1: begin legal = 1'b1;         lane_mask = 32'h0000_00FF << shamt; end
      3'd2: begin legal = ~off[0];      lane_mask = 32'h0000_FFFF << shamt; end
      3'd4: begin legal = (off == 2'd0); lane_mask = 32'hFFFF_FFFF; end
      default: ;
    endcase
  end

  assign lane_data = wr_data << shamt;
  assign wr_go     = wr_en & legal & in_range;
endmodule

// File: rtl/pcfg_regfile.sv
module pcfg_regfile #(
  parameter int          NREG       = 64,
  parameter int          NBAR       = 6,
  parameter int          RD_IDX_W   = 8,
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h7A31,
  parameter logic [7:0]  CLASS_CODE = 8'h04,
  parameter logic [7:0]  SUBCLASS   = 8'h01,
  parameter logic [7:0]  PROG_IF    = 8'h5A,
  parameter logic [7:0]  REVISION   = 8'h02,
  parameter logic [15:0] SUBSYS_VID = 16'hABCD,
  parameter logic [15:0] SUBSYS_ID  = 16'h2468,
  parameter bit          HDR_BRIDGE = 1'b0,
  parameter logic [1:0]  IRQ_PIN_SEL = 2'd0,
  parameter logic [7:0]  IRQ_LINE   = 8'h0B,
  parameter logic [2*NBAR-1:0]  BAR_KIND = 12'h02D,
  parameter logic [6*NBAR-1:0]  BAR_LOG2 = {6'd0, 6'd0, 6'd0, 6'd33, 6'd5, 6'd12},
  parameter logic [NBAR-1:0]    BAR_PREF = 6'b000100,
  parameter logic [64*NBAR-1:0] BAR_ADDR = {64'h0, 64'h0, 64'h0,
                                            64'h0000_0004_0000_0000,
                                            64'h0000_0000_0000_C000,
                                            64'h0000_0000_FEB0_0000}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [RD_IDX_W-1:0]   rd_idx,
  output logic [31:0]           rd_data,
  input  logic                  wr_en,
  input  logic [RD_IDX_W+1:0]   wr_addr,
  input  logic [2:0]            wr_size,
  input  logic [31:0]           wr_data
);
  localparam int IDX_W = $clog2(NREG);
  localparam int AW    = RD_IDX_W + 2;

  logic [NREG-1:0][31:0] init_val;
  logic [NREG-1:0][31:0] init_mask;
  logic [31:0]           regs [NREG];

  logic             wr_go;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      lane_mask;
  logic [31:0]      lane_data;
  logic [31:0]      eff_mask;

  pcfg_init #(
    .NREG(NREG), .NBAR(NBAR),
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .CLASS_CODE(CLASS_CODE), .SUBCLASS(SUBCLASS), .PROG_IF(PROG_IF),
    .REVISION(REVISION), .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID(SUBSYS_ID),
    .HDR_BRIDGE(HDR_BRIDGE), .IRQ_PIN_SEL(IRQ_PIN_SEL), .IRQ_LINE(IRQ_LINE),
    .BAR_KIND(BAR_KIND), .BAR_LOG2(BAR_LOG2), .BAR_PREF(BAR_PREF),
    .BAR_ADDR(BAR_ADDR)
  ) u_init (
    .init_val  (init_val),
    .init_mask (init_mask)
  );

  pcfg_wr_lane #(.NREG(NREG), .AW(AW), .IDX_W(IDX_W)) u_lane (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_size   (wr_size),
    .wr_data   (wr_data),
    .wr_go     (wr_go),
    .wr_idx    (wr_idx),
    .lane_mask (lane_mask),
    .lane_data (lane_data)
  );

  assign eff_mask = lane_mask & init_mask[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= init_val[i];
    end else if (wr_go) begin
      regs[wr_idx] <= (regs[wr_idx] & ~eff_mask) | (lane_data & eff_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_idx < RD_IDX_W'(NREG)) rd_data <= regs[rd_idx[IDX_W-1:0]];
      else                          rd_data <= 32'hFFFF_FFFF;
    end
  end

endmodule

// File: rtl/pcfg_regfile_chk.sv
module pcfg_regfile_chk #(
  parameter int          NREG       = 64,
  parameter int          RD_IDX_W   = 8,
  parameter logic [15:0] VENDOR_ID  = 16'h0,
  parameter logic [15:0] DEVICE_ID  = 16'h0,
  parameter logic [7:0]  CLASS_CODE = 8'h0,
  parameter logic [7:0]  SUBCLASS   = 8'h0,
  parameter logic [7:0]  PROG_IF    = 8'h0,
  parameter logic [7:0]  REVISION   = 8'h0,
  parameter logic [15:0] SUBSYS_VID = 16'h0,
  parameter logic [15:0] SUBSYS_ID  = 16'h0,
  parameter bit          HDR_BRIDGE = 1'b0,
  parameter logic [1:0]  IRQ_PIN_SEL = 2'd0
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic [RD_IDX_W-1:0] rd_idx,
  input logic [31:0]         rd_data
);
  localparam logic [7:0] PIN_CODE = 8'(IRQ_PIN_SEL) + 8'd1;

  AST_OOR_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx >= RD_IDX_W'(NREG) |=> rd_data == 32'hFFFF_FFFF); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R2
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx == RD_IDX_W'(0) |=> rd_data == {DEVICE_ID, VENDOR_ID}); // R1
  AST_CLASS_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx == RD_IDX_W'(2) |=>
      rd_data == {CLASS_CODE, SUBCLASS, PROG_IF, REVISION}); // R1
  AST_SUBSYS_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx == RD_IDX_W'(11) |=> rd_data == {SUBSYS_ID, SUBSYS_VID}); // R1
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx == RD_IDX_W'(1) |=> rd_data[31:16] == 16'h0); // R4
  AST_HDR_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx == RD_IDX_W'(3) |=>
      rd_data[31:8] == (HDR_BRIDGE ? 24'h000100 : 24'h0)); // R6
  AST_PIN_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_idx == RD_IDX_W'(15) |=> rd_data[15:8] == PIN_CODE); // R10
endmodule

bind pcfg_regfile pcfg_regfile_chk #(
  .NREG(NREG), .RD_IDX_W(RD_IDX_W),
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
  .CLASS_CODE(CLASS_CODE), .SUBCLASS(SUBCLASS), .PROG_IF(PROG_IF),
  .REVISION(REVISION), .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID(SUBSYS_ID),
  .HDR_BRIDGE(HDR_BRIDGE), .IRQ_PIN_SEL(IRQ_PIN_SEL)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/test_pcfg_regfile.sv
module test_pcfg_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_idx = '0;
  logic [31:0] rd_data, rd_data_b;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [2:0]  wr_size = '0;
  logic [31:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pcfg_regfile i_pcfg_regfile (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data)
  );

  // Bridge-header instance without BARs, sharing the host bus
  pcfg_regfile #(.HDR_BRIDGE(1'b1), .BAR_KIND(12'h000)) i_pcfg_regfile_b (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [9:0] a, logic [31:0] d, logic [2:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [7:0] idx, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
    a = rd_data;
    b = rd_data_b;
  endtask

  task automatic expect_reg(string req, logic [7:0] idx, logic [31:0] exp);
    logic [31:0] a, b;
    do_read(idx, a, b);
    check(req, a, exp);
  endtask

  task automatic expect_brg(string req, logic [7:0] idx, logic [31:0] exp);
    logic [31:0] a, b;
    do_read(idx, a, b);
    check(req, b, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 id", 8'd0, 32'h7A31_C0DE);
    expect_reg("R1 class", 8'd2, 32'h0401_5A02);
    expect_reg("R1 subsys", 8'd11, 32'h2468_ABCD);
    expect_reg("R9 command", 8'd1, 32'h0000_0003);
    expect_reg("R6 hdr0", 8'd3, 32'h0000_0000);
    expect_reg("R10 irq", 8'd15, 32'h0000_010B);
  endtask

  task automatic t_bridge;
    expect_brg("R6 hdr1", 8'd3, 32'h0001_0000);
    expect_brg("R9 no bars", 8'd1, 32'h0000_0000);
    do_write(10'h024, 32'hFFFF_FFFF, 3'd4);
    expect_brg("R6 window mask", 8'd9, 32'hFFF0_FFF0);
    expect_reg("R6 hdr0 reg9 ro", 8'd9, 32'h0000_0000);
    do_write(10'h03C, 32'hFFFF_FFFF, 3'd4);
    expect_brg("R6 irq mask hdr1", 8'd15, 32'hFFFF_01FF);
    expect_reg("R6 irq mask hdr0", 8'd15, 32'h0000_01FF);
  endtask

  task automatic t_readonly;
    do_write(10'h000, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R3 id ro", 8'd0, 32'h7A31_C0DE);
    do_write(10'h008, 32'h1111_1111, 3'd4);
    expect_reg("R1 class ro", 8'd2, 32'h0401_5A02);
    do_write(10'h004, 32'hFFFF_1234, 3'd4);
    expect_reg("R4 command", 8'd1, 32'h0000_1234);
  endtask

  task automatic t_sizes;
    logic [31:0] a, b;
    do_write(10'h00C, 32'h0000_0040, 3'd1);
    expect_reg("R5 byte", 8'd3, 32'h0000_0040);
    do_write(10'h006, 32'h0000_BEEF, 3'd2);
    expect_reg("R4 status ro", 8'd1, 32'h0000_1234);
    do_write(10'h004, 32'h0000_5678, 3'd2);
    expect_reg("R5 word", 8'd1, 32'h0000_5678);
    do_write(10'h005, 32'h0000_9999, 3'd2);
    expect_reg("R5 odd word", 8'd1, 32'h0000_5678);
    do_write(10'h00D, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R5 misaligned dword", 8'd3, 32'h0000_0040);
    do_write(10'h00C, 32'h0000_0077, 3'd3);
    expect_reg("R5 bad size", 8'd3, 32'h0000_0040);
    do_write(10'h00D, 32'h0000_0055, 3'd1);
    expect_reg("R3 ro byte", 8'd3, 32'h0000_0040);
    do_write(10'h104, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R5 out of range write", 8'd1, 32'h0000_5678);
    do_write(10'h03C, 32'h0000_0022, 3'd1);
    expect_reg("R10 line", 8'd15, 32'h0000_0122);
    do_write(10'h03D, 32'h0000_0007, 3'd1);
    expect_reg("R10 pin ro", 8'd15, 32'h0000_0122);
    expect_reg("R2 idx 64", 8'd64, 32'hFFFF_FFFF);
    expect_reg("R2 idx 200", 8'd200, 32'hFFFF_FFFF);
    do_read(8'd11, a, b);
    repeat (3) @(negedge clk);
    check("R2 hold", rd_data, 32'h2468_ABCD);
  endtask

  task automatic t_bar;
    expect_reg("R7 mem32 reset", 8'd4, 32'hFEB0_0000);
    do_write(10'h010, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R7 mem32 size", 8'd4, 32'hFFFF_F000);
    do_write(10'h010, 32'h1234_5678, 3'd4);
    expect_reg("R7 mem32 addr", 8'd4, 32'h1234_5000);
    expect_reg("R7 io reset", 8'd5, 32'h0000_C001);
    do_write(10'h014, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R7 io size", 8'd5, 32'hFFFF_FFE1);
    do_write(10'h018, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R7 mem64 low", 8'd6, 32'h0000_000C);
    expect_reg("R8 upper reset", 8'd7, 32'h0000_0004);
    do_write(10'h01C, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R8 upper size", 8'd7, 32'hFFFF_FFFE);
    do_write(10'h020, 32'hFFFF_FFFF, 3'd4);
    expect_reg("R7 unused slot", 8'd8, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_bridge;
    t_readonly;
    t_sizes;
    t_bar;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule